// File: doc/BRIEF.md
# Priority Interrupt Nesting Controller

This block chooses between interrupt requests at three maskable priority levels (low, medium, high) and one non-maskable level. A request may interrupt a running handler only when its level is strictly above every handler that is already executing. The block records each level that has been accepted and not yet returned from in a sticky "executing" bitmap. Software reads that bitmap as an 8-bit status byte and can work out the whole nesting stack from it, so it does not need its own depth counter.

When a request is accepted, the block raises a one-cycle taken strobe. Alongside it come the 2-bit granted level and a vector index computed from that level. On the same clock edge the level's flag is set. A return strobe closes the innermost handler by clearing the highest set flag, so flags of lower handlers that were preempted stay visible. Software may also overwrite the flags through a write port. Bits that have no meaning read as zero, and writes to them are discarded.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 0x00 and the taken strobe is low.
- R2: Status byte layout: bit 7 = non-maskable executing, bit 2 = high executing, bit 1 = medium executing, bit 0 = low executing. Bits 6..3 always read 0, and write data on those bits is discarded.
- R3: An accepted request pulses `taken_o` high for exactly one cycle. In that cycle `lvl_o` carries the level (0 low, 1 medium, 2 high, 3 non-maskable) and `vec_o` = VEC_BASE + level*VEC_STEP (defaults give 4, 6, 8, 10). The level's status flag is set on the same edge.
- R4: A request is accepted only if its level is strictly above the highest level whose flag is set. A request at or below that level stays pending without effect. For example, high accepted over a running low gives 0x05, and high accepted from thread context gives 0x04.
- R5: A maskable request is eligible only while both `gie_i` and its bit of `lvl_en_i` are 1. Bit 0 of `lvl_en_i` enables low, bit 1 enables medium and bit 2 enables high.
- R6: The non-maskable request is accepted whenever the non-maskable flag is clear, whatever the values of `gie_i` and `lvl_en_i`.
- R7: When several levels are eligible in one cycle, the highest level is granted.
- R8: A return strobe clears only the highest set flag, in the order bit 7, then 2, then 1, then 0. A return while no flag is set changes nothing.
- R9: A status write replaces bits 7, 2, 1 and 0 with the written data. In a given cycle a write takes precedence over a return, and a write or a return blocks acceptance in that cycle (no taken pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 3 | Maskable request lines, bit 0 low, bit 1 medium, bit 2 high |
| nmi_req_i | input | 1 | Non-maskable request |
| gie_i | input | 1 | Global enable for maskable levels |
| lvl_en_i | input | 3 | Per-level enables, same bit order as req_i |
| ret_i | input | 1 | Return-from-handler strobe |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 8 | Status write data |
| taken_o | output | 1 | One-cycle acceptance strobe |
| lvl_o | output | 2 | Level of the latest acceptance |
| vec_o | output | VEC_W | Vector index of the latest acceptance |
| status_o | output | 8 | Executing-flags status byte |

## Verification
A flag that is wrong inside the block appears on `status_o` on the edge after the event that caused it. It also changes which later requests are accepted. A flag left set by mistake suppresses taken pulses for equal and lower levels. A flag cleared by mistake lets a re-entrant grant through on the next cycle. A return that clears the wrong flag is visible at once as a wrong status byte, such as 0x04 where 0x01 is expected after returning from a preempting high handler. The directed scenarios therefore read the status byte after every single step.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
    localparam int NUM_LVL = 4;          // low, medium, high, non-maskable
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int RANK_W  = $clog2(NUM_LVL + 1);
    localparam int NMI_IDX = NUM_LVL - 1;

    typedef logic [NUM_LVL-1:0] flags_t;

    typedef struct packed {
        flags_t            flags;
        logic              taken;
        logic [LVL_W-1:0]  lvl;
    } ctrl_state_t;

    // Rank of innermost executing level: 0 = thread context, i+1 = level i
    function automatic logic [RANK_W-1:0] top_rank(flags_t f);
        logic [RANK_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (f[i]) r = RANK_W'(i + 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/nest_irq_pick.sv
module nest_irq_pick
    import nest_irq_pkg::*;
(
    input  logic [NUM_LVL-2:0] req_i,
    input  logic               nmi_req_i,
    input  logic               gie_i,
    input  logic [NUM_LVL-2:0] lvl_en_i,
    input  flags_t             flags_i,
    output logic               grant_v_o,
    output logic [LVL_W-1:0]   grant_lvl_o
);
    logic [RANK_W-1:0]  cur_rank;
    logic [NUM_LVL-1:0] elig;

    assign cur_rank = top_rank(flags_i);

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
        if (g == NMI_IDX) begin : g_nmi
            assign elig[g] = nmi_req_i && (RANK_W'(g + 1) > cur_rank);
        end else begin : g_mask
            assign elig[g] = req_i[g] && gie_i && lvl_en_i[g]
                             && (RANK_W'(g + 1) > cur_rank);
        end
    end

    always_comb begin
        grant_v_o   = 1'b0;
        grant_lvl_o = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (elig[i]) begin
                grant_v_o   = 1'b1;
                grant_lvl_o = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/nest_irq_state.sv
module nest_irq_state
    import nest_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_v_i,
    input  logic [LVL_W-1:0] grant_lvl_i,
    input  logic             ret_i,
    input  logic             we_i,
    input  flags_t           wflags_i,
    output flags_t           flags_o,
    output logic             taken_o,
    output logic [LVL_W-1:0] lvl_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        logic done;
        st_d       = st_q;
        st_d.taken = 1'b0;
        done       = 1'b0;
        if (we_i) begin
            st_d.flags = wflags_i;
        end else if (ret_i) begin
            for (int i = NUM_LVL - 1; i >= 0; i--) begin
                if (!done && st_q.flags[i]) begin
                    st_d.flags[i] = 1'b0;
                    done          = 1'b1;
                end
            end
        end else if (grant_v_i) begin
            st_d.flags[grant_lvl_i] = 1'b1;
            st_d.taken              = 1'b1;
            st_d.lvl                = grant_lvl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign taken_o = st_q.taken;
    assign lvl_o   = st_q.lvl;

    // R3
    taken_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.taken |-> st_q.flags[st_q.lvl]);

    // R4
    preempt_only_higher_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_v_i && !we_i && !ret_i) |=>
            (RANK_W'(st_q.lvl) + RANK_W'(1) > top_rank($past(st_q.flags))));

    // R8
    ret_clears_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !we_i && (st_q.flags != '0)) |=>
            ($countones(st_q.flags) + 1 == $countones($past(st_q.flags)))
            && !st_q.taken);

    // R9
    write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (st_q.flags == $past(wflags_i)) && !st_q.taken);

    // R6
    nmi_always_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_v_i && (grant_lvl_i == LVL_W'(NMI_IDX)) && !we_i && !ret_i) |=>
            st_q.taken && (st_q.lvl == LVL_W'(NMI_IDX)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       req_i,
    input  logic             nmi_req_i,
    input  logic             gie_i,
    input  logic [2:0]       lvl_en_i,
    input  logic             ret_i,
    input  logic             stat_we_i,
    input  logic [7:0]       stat_wdata_i,
    output logic             taken_o,
    output logic [1:0]       lvl_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [7:0]       status_o
);
    localparam int NMI_BIT = 7;

    flags_t           flags, wflags;
    logic             grant_v;
    logic [LVL_W-1:0] grant_lvl;

    // maskable levels keep their bit index, non-maskable sits at the top bit
    assign wflags = {stat_wdata_i[NMI_BIT], stat_wdata_i[NUM_LVL-2:0]};

    nest_irq_pick u_pick (
        .req_i       (req_i),
        .nmi_req_i   (nmi_req_i),
        .gie_i       (gie_i),
        .lvl_en_i    (lvl_en_i),
        .flags_i     (flags),
        .grant_v_o   (grant_v),
        .grant_lvl_o (grant_lvl)
    );

    nest_irq_state u_state (
        .clk         (clk),
        .rst         (rst),
        .grant_v_i   (grant_v),
        .grant_lvl_i (grant_lvl),
        .ret_i       (ret_i),
        .we_i        (stat_we_i),
        .wflags_i    (wflags),
        .flags_o     (flags),
        .taken_o     (taken_o),
        .lvl_o       (lvl_o)
    );

    always_comb begin
        status_o                 = '0;
        status_o[NUM_LVL-2:0]    = flags[NUM_LVL-2:0];
        status_o[NMI_BIT]        = flags[NMI_IDX];
    end

    assign vec_o = VEC_W'(VEC_BASE) + VEC_W'(lvl_o) * VEC_W'(VEC_STEP);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_we_i |=> (status_o[6:3] == 4'b0000));
endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] req;
    logic       nmi, gie, ret, we;
    logic [2:0] en;
    logic [7:0] wd;
    logic       taken;
    logic [1:0] lvl;
    logic [7:0] vec;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    nest_irq_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req), .nmi_req_i(nmi), .gie_i(gie),
        .lvl_en_i(en), .ret_i(ret), .stat_we_i(we), .stat_wdata_i(wd),
        .taken_o(taken), .lvl_o(lvl), .vec_o(vec), .status_o(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // apply inputs for one clock, then clear and sample after the edge
    task automatic step(input logic [2:0] r, input logic n, input logic rt,
                        input logic w, input logic [7:0] d);
        req = r; nmi = n; ret = rt; we = w; wd = d;
        @(negedge clk);
        req = '0; nmi = 0; ret = 0; we = 0; wd = '0;
    endtask

    task automatic expect_take(input string tag, input int l, input int st);
        chk({tag, " taken"}, taken, 1);
        chk({tag, " lvl"}, lvl, l);
        chk({tag, " vec"}, vec, 4 + 2 * l);
        chk({tag, " status"}, status, st);
    endtask

    task automatic expect_idle(input string tag, input int st);
        chk({tag, " taken"}, taken, 0);
        chk({tag, " status"}, status, st);
    endtask

    task automatic t_reset();
        expect_idle("R1 reset", 8'h00);
    endtask

    task automatic t_low_single();
        step(3'b001, 0, 0, 0, 0); expect_take("R3 low accept", 0, 8'h01);
        step(3'b001, 0, 0, 0, 0); expect_idle("R4 same level held", 8'h01);
        step(3'b000, 0, 0, 0, 0); expect_idle("R3 one-cycle strobe", 8'h01);
    endtask

    task automatic t_preempt();
        step(3'b100, 0, 0, 0, 0); expect_take("R4 high over low", 2, 8'h05);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret from high", 8'h01);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret from low", 8'h00);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret none ignored", 8'h00);
    endtask

    task automatic t_block_lower();
        step(3'b100, 0, 0, 0, 0); expect_take("R4 high from thread", 2, 8'h04);
        step(3'b010, 0, 0, 0, 0); expect_idle("R4 medium blocked", 8'h04);
        step(0, 1, 0, 0, 0); expect_take("R6 nmi over high", 3, 8'h84);
        step(0, 1, 0, 0, 0); expect_idle("R6 nmi not reentered", 8'h84);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret from nmi", 8'h04);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret from high", 8'h00);
    endtask

    task automatic t_gie_off();
        gie = 0;
        step(3'b111, 0, 0, 0, 0); expect_idle("R5 gie off", 8'h00);
        step(0, 1, 0, 0, 0); expect_take("R6 nmi gie off", 3, 8'h80);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret nmi", 8'h00);
        gie = 1;
    endtask

    task automatic t_simul();
        step(3'b011, 0, 0, 0, 0); expect_take("R7 med beats low", 1, 8'h02);
        step(3'b111, 1, 0, 0, 0); expect_take("R7 nmi beats all", 3, 8'h82);
        step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
        expect_idle("R8 unwind", 8'h00);
    endtask

    task automatic t_level_en();
        en = 3'b110;
        step(3'b001, 0, 0, 0, 0); expect_idle("R5 low disabled", 8'h00);
        en = 3'b011;
        step(3'b100, 0, 0, 0, 0); expect_idle("R5 high disabled", 8'h00);
        en = 3'b111;
    endtask

    task automatic t_write();
        step(0, 0, 0, 1, 8'hFF); expect_idle("R2 reserved dropped", 8'h87);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret clears nmi first", 8'h07);
        step(0, 0, 1, 0, 0); expect_idle("R8 ret clears high next", 8'h03);
        step(3'b100, 0, 1, 1, 8'h78); expect_idle("R9 write over ret", 8'h00);
        step(3'b001, 0, 1, 0, 0); expect_idle("R9 ret blocks accept", 8'h00);
        step(3'b001, 0, 0, 1, 8'h02); expect_idle("R9 write blocks accept", 8'h02);
        step(3'b100, 0, 0, 0, 0); expect_take("R4 high over written med", 2, 8'h06);
        step(0, 0, 0, 1, 8'h00); expect_idle("R9 clear by write", 8'h00);
    endtask

    initial begin
        rst = 1; req = '0; nmi = 0; gie = 1; en = 3'b111; ret = 0; we = 0; wd = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_low_single();
        t_preempt();
        t_block_lower();
        t_gie_off();
        t_simul();
        t_level_en();
        t_write();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule